// File: doc/BRIEF.md
# Call and Interrupt Return Stack

This block is a small hardware stack that holds return addresses for a 4-bit controller core. Each time a subroutine is called or an interrupt is taken, the core pushes the address it will resume at, along with the current carry flag. The two are packed into one entry: the carry in the top bit and the program counter below it. Calls and interrupts use the same stack. Entries come back in last-in, first-out order.

Returns come in two kinds. An interrupt return pops the address and also gives back the saved carry. A return that loads a constant pops the address but leaves the live carry unchanged. The stack has a fixed depth. If a push arrives when the stack is full, the oldest entry is lost and the push is not refused. A sticky flag records that this happened. A second sticky flag records a pop made while the stack was empty.

The popped address and the carry value to use next are combinational outputs. They are valid in the same cycle as the pop request, so the core can load its program counter on that clock edge.

Top module: `ret_stack`

## Requirements
- R1: After reset `depth` is 0, `overflow` and `underflow` are 0, and every entry is zero, so `ret_pc` reads 0.
- R2: A push without a pop stores `{push_cy, push_pc}` as the new top entry, with the carry in bit PCW and the address in bits PCW-1..0. If `depth` is below DEPTH, it rises by one on that edge.
- R3: `ret_pc` always shows the address of the top entry. Successive pops return addresses in last-in, first-out order. A pop at non-zero depth lowers `depth` by one, and each older entry moves up one place.
- R4: When `pop` is high and `pop_restore` is 1 (interrupt return), `cy_out` equals the carry saved in the top entry.
- R5: When `pop` is high and `pop_restore` is 0 (constant return), or when `pop` is low, `cy_out` equals `cy_in`. The saved carry has no effect in this case.
- R6: A push without a pop at `depth` == DEPTH discards the bottom entry. `depth` stays at DEPTH, and `overflow` goes to 1 on that edge. It stays at 1 until reset.
- R7: A pop without a push at `depth` 0 returns the current top entry. The entries are not shifted, `depth` stays 0, and `underflow` goes to 1. It stays at 1 until reset. Because a pop leaves the bottom entry in place as well as copying it upward, after the stack is drained the top holds the last entry that occupied the bottom.
- R8: A push and a pop in the same cycle return the current top on `ret_pc`/`cy_out`. On the edge, the top entry is replaced by the pushed value and `depth` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Save a return entry (call or interrupt entry) |
| push_pc | input | PCW | Return address to save |
| push_cy | input | 1 | Carry flag to save with it |
| pop | input | 1 | Take the top entry (return) |
| pop_restore | input | 1 | 1: interrupt return restores carry; 0: carry kept |
| cy_in | input | 1 | Live carry flag of the core |
| ret_pc | output | PCW | Address held in the top entry |
| cy_out | output | 1 | Carry value the core should hold after this cycle |
| depth | output | $clog2(DEPTH+1) | Number of live entries, 0..DEPTH |
| overflow | output | 1 | Sticky: a push was made at full depth |
| underflow | output | 1 | Sticky: a pop was made at depth 0 |

## Verification
The bench uses the default build: DEPTH = 4 and PCW = 12. With only four levels, a short sequence is enough to fill the stack, push a fifth entry, and then drain it. That makes the lost bottom entry visible in the return order. It also means the stale value left in the top slot can be predicted for the empty-pop case. A 12-bit address allows patterns such as 0xFFF and 0x001, which exercise every address bit next to the carry bit during both push and pop.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 4,
  parameter int PCW   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [PCW-1:0]             push_pc,
  input  logic                       push_cy,
  input  logic                       pop,
  input  logic                       pop_restore,
  input  logic                       cy_in,
  output logic [PCW-1:0]             ret_pc,
  output logic                       cy_out,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic                       overflow,
  output logic                       underflow
);
  localparam int EW = PCW + 1;
  localparam int DW = $clog2(DEPTH+1);
  localparam logic [DW-1:0] FULL = DW'(DEPTH);

  logic [EW-1:0] stk     [DEPTH];
  logic [EW-1:0] stk_nxt [DEPTH];
  logic          empty, full;

  assign empty  = (depth == '0);
  assign full   = (depth == FULL);
  assign ret_pc = stk[0][PCW-1:0];
  assign cy_out = (pop && pop_restore) ? stk[0][PCW] : cy_in;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) stk_nxt[i] = stk[i];
    if (push && pop) begin
      stk_nxt[0] = {push_cy, push_pc};
    end else if (push) begin
      for (int i = DEPTH-1; i > 0; i--) stk_nxt[i] = stk[i-1];
      stk_nxt[0] = {push_cy, push_pc};
    end else if (pop && !empty) begin
      for (int i = 0; i < DEPTH-1; i++) stk_nxt[i] = stk[i+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) stk[i] <= stk_nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (push && !pop) begin
      if (full) overflow <= 1'b1;
      else      depth    <= depth + 1'b1;
    end else if (pop && !push) begin
      if (empty) underflow <= 1'b1;
      else       depth     <= depth - 1'b1;
    end
  end
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int DEPTH = 4,
  parameter int PCW   = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       push,
  input logic [PCW-1:0]             push_pc,
  input logic                       push_cy,
  input logic                       pop,
  input logic                       pop_restore,
  input logic                       cy_in,
  input logic [PCW-1:0]             ret_pc,
  input logic                       cy_out,
  input logic [$clog2(DEPTH+1)-1:0] depth,
  input logic                       overflow,
  input logic                       underflow
);
  localparam int DW = $clog2(DEPTH+1);

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));                                                   // R2
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && depth < DW'(DEPTH)) |=> depth == $past(depth) + 1'b1); // R2
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> ret_pc == $past(push_pc));                           // R2
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth != '0) |=> depth == $past(depth) - 1'b1);        // R3
  AST_KEEP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !pop_restore) |-> cy_out == cy_in);                             // R5
  AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && depth == DW'(DEPTH)) |=> overflow && depth == DW'(DEPTH)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);                                                 // R6
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && depth == '0) |=> underflow && depth == '0);            // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);                                               // R7
  AST_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> depth == $past(depth) && ret_pc == $past(push_pc));   // R8
endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .push_pc(push_pc), .push_cy(push_cy),
  .pop(pop), .pop_restore(pop_restore), .cy_in(cy_in), .ret_pc(ret_pc),
  .cy_out(cy_out), .depth(depth), .overflow(overflow), .underflow(underflow)
);

// File: tb/ret_stack_bench.sv
module ret_stack_bench;
  localparam int DEPTH = 4;
  localparam int PCW   = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push = 0, pop = 0, pop_restore = 0, push_cy = 0, cy_in = 0;
  logic [PCW-1:0] push_pc = '0;
  logic [PCW-1:0] ret_pc;
  logic cy_out, overflow, underflow;
  logic [2:0] depth;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  ret_stack #(.DEPTH(DEPTH), .PCW(PCW)) u_ret_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .push_pc(push_pc), .push_cy(push_cy),
    .pop(pop), .pop_restore(pop_restore), .cy_in(cy_in), .ret_pc(ret_pc),
    .cy_out(cy_out), .depth(depth), .overflow(overflow), .underflow(underflow));

  // {push, pop, restore, cy, pc[11:0], exp_pc[11:0], exp_cy, exp_depth[2:0]}
  localparam int NV = 13;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,12'h100,12'h000,1'b0,3'd1},
    {1'b1,1'b0,1'b0,1'b0,12'h200,12'h000,1'b0,3'd2},
    {1'b1,1'b0,1'b0,1'b1,12'h300,12'h000,1'b0,3'd3},
    {1'b0,1'b1,1'b1,1'b0,12'h000,12'h300,1'b1,3'd2},
    {1'b0,1'b1,1'b0,1'b1,12'h000,12'h200,1'b1,3'd1},
    {1'b1,1'b0,1'b0,1'b0,12'h2AB,12'h000,1'b0,3'd2},
    {1'b1,1'b0,1'b0,1'b1,12'h3CD,12'h000,1'b0,3'd3},
    {1'b1,1'b0,1'b0,1'b0,12'hFFF,12'h000,1'b0,3'd4},
    {1'b1,1'b0,1'b0,1'b1,12'h001,12'h000,1'b0,3'd4},
    {1'b0,1'b1,1'b1,1'b0,12'h000,12'h001,1'b1,3'd3},
    {1'b0,1'b1,1'b0,1'b0,12'h000,12'hFFF,1'b0,3'd2},
    {1'b0,1'b1,1'b1,1'b0,12'h000,12'h3CD,1'b1,3'd1},
    {1'b0,1'b1,1'b1,1'b1,12'h000,12'h2AB,1'b0,3'd0}
  };

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic pu, input logic po, input logic rs,
                       input logic cy, input logic [PCW-1:0] pc);
    push = pu; pop = po; pop_restore = rs; cy_in = cy; push_cy = cy; push_pc = pc;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 depth", depth, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 underflow", underflow, 0);
    chk("R1 ret_pc", ret_pc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31], VEC[i][30], VEC[i][29], VEC[i][28], VEC[i][27:16]);
      #2;
      if (VEC[i][30]) begin
        chk("R3 pop order", ret_pc, VEC[i][15:4]);
        chk(VEC[i][29] ? "R4 carry restored" : "R5 carry kept", cy_out, VEC[i][3]);
      end
      if (i == 8) chk("R6 no overflow before", overflow, 0);
      @(negedge clk);
      chk(i == 8 ? "R6 depth saturates" : (VEC[i][31] ? "R2 depth" : "R3 depth"),
          depth, VEC[i][2:0]);
      if (VEC[i][31]) chk("R2 top after push", ret_pc, VEC[i][27:16]);
      if (i == 8) chk("R6 overflow set", overflow, 1);
    end
    drive(0, 0, 0, 0, '0);
    chk("R6 overflow sticky", overflow, 1);

    // R7: pop at depth 0 returns stale top (last bottom occupant 0x2AB, cy 0)
    drive(0, 1, 1, 1, '0);
    #2;
    chk("R7 stale pc", ret_pc, 12'h2AB);
    chk("R7 stale cy", cy_out, 0);
    @(negedge clk);
    chk("R7 depth", depth, 0);
    chk("R7 underflow", underflow, 1);
    drive(0, 0, 0, 0, '0);
    @(negedge clk);
    chk("R7 underflow sticky", underflow, 1);

    // R8: simultaneous push and pop
    drive(1, 0, 0, 0, 12'h111); @(negedge clk);
    drive(1, 0, 0, 1, 12'h222); @(negedge clk);
    drive(1, 1, 1, 0, 12'h333);
    #2;
    chk("R8 returns old top", ret_pc, 12'h222);
    chk("R8 old carry", cy_out, 1);
    @(negedge clk);
    chk("R8 depth kept", depth, 2);
    drive(0, 1, 1, 1, '0);
    #2;
    chk("R8 replaced top", ret_pc, 12'h333);
    chk("R8 replaced carry", cy_out, 0);
    @(negedge clk);
    drive(0, 1, 0, 0, '0);
    #2;
    chk("R3 below swap", ret_pc, 12'h111);
    chk("R5 idle carry", cy_out, 0);
    @(negedge clk);
    chk("R3 drained", depth, 0);
    drive(0, 0, 0, 1, '0);
    #2;
    chk("R5 no pop carry", cy_out, 1);

    // R1: reset again clears flags
    rst_n = 1'b0;
    #2;
    chk("R1 overflow cleared", overflow, 0);
    chk("R1 underflow cleared", underflow, 0);
    chk("R1 entries cleared", ret_pc, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule